// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Superpage Masks

This block caches recent virtual-to-physical translations for a 64-bit virtual-memory unit. Each slot keeps an address-space identifier, a global flag, and the page-aligned virtual tag. It also keeps the page-aligned physical base, the leaf page-table entry with the address it was read from, and a match mask. The mask is derived from the page-table level where the walk ended, so 4 KiB, 2 MiB and 1 GiB pages share the same slots. A lookup is purely combinational from the stored slots. It returns a hit flag, the translated physical address, the leaf entry and the address of that entry. The address of the entry is kept only for a later dirty-bit writeback.

A fill port writes a finished walk result. The slot is chosen as the first free one; when no slot is free, the one filled longest ago is replaced. A fence port invalidates slots and takes an optional identifier and an optional address. The four combinations of these give four selection rules, and global slots survive any fence that names an identifier. An init pulse empties the whole cache.

Top module: `tlb_cache`

## Requirements
- R1: A lookup hits only when a valid slot is global or holds the request identifier, and its stored tag equals the request virtual address ANDed with the slot's match mask. On a hit, the physical address is the stored base ORed with the request address bits outside the match mask.
- R2: The page shift on fill is 12 + 9 x level. Level 0, 1 and 2 cover 4 KiB, 2 MiB and 1 GiB, and the match mask is all ones above the shift.
- R3: The stored tag and stored physical base have their low shift bits cleared, so low bits of the fill addresses never reach the lookup result.
- R4: A fence with neither identifier nor address invalidates every slot, global ones included.
- R5: A fence with only an address invalidates every slot whose tag equals the fence address under that slot's mask, whatever its identifier or global flag.
- R6: A fence with only an identifier invalidates non-global slots holding that identifier. Only the low 16 bits of the 64-bit fence identifier operand are compared.
- R7: A fence with both fields invalidates only non-global slots that match both the identifier and the masked address.
- R8: A fill writes the lowest-numbered free slot. When all slots are full, it writes the slot with the oldest fill time, taken from a free-running cycle counter.
- R9: When a fence or an init pulse and a fill share a cycle, the invalidation applies first and the fill afterwards, so the new slot survives.
- R10: After reset the cache holds no valid slot and no lookup hits.
- R11: When several slots match a lookup, the lowest-numbered one supplies the result.
- R12: On a hit the leaf entry and its address come from the hit slot. On a miss the physical address, leaf entry and entry address outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Empties all slots this cycle |
| lk_asid_i | input | 16 | Lookup address-space identifier |
| lk_vaddr_i | input | 64 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | 64 | Translated physical address |
| lk_pte_o | output | 64 | Leaf page-table entry of the hit slot |
| lk_pte_addr_o | output | 64 | Address of that leaf entry |
| fill_valid_i | input | 1 | Fill request |
| fill_asid_i | input | 16 | Fill identifier |
| fill_glob_i | input | 1 | Fill is a global mapping |
| fill_level_i | input | 2 | Walk level of the leaf |
| fill_vaddr_i | input | 64 | Fill virtual address |
| fill_paddr_i | input | 64 | Fill physical address |
| fill_pte_i | input | 64 | Leaf page-table entry |
| fill_pte_addr_i | input | 64 | Address of the leaf entry |
| fence_valid_i | input | 1 | Fence request |
| fence_use_asid_i | input | 1 | Fence names an identifier |
| fence_asid_i | input | 64 | Fence identifier operand (low 16 bits used) |
| fence_use_addr_i | input | 1 | Fence names an address |
| fence_addr_i | input | 64 | Fence virtual address |

## Verification
Directed lookups probe offsets that stay inside a page and one step past each boundary at all three levels. This separates a correct mask from one that is a level too wide or too narrow. Fences are run in each of the four identifier/address combinations against a mix of global and non-global slots, and one of them has junk in the upper identifier bits. This shows whether global slots survive, whether the truncation is applied, and whether the cases are kept apart. Fills past capacity, a freed middle slot and duplicate pages expose the victim order and the hit priority. Long random runs over a small pool of identifiers and pages then mix fills, fences and init against a bench model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W = 16;
  localparam int ADDR_W = 64;
  localparam int PTE_W  = 64;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [ADDR_W-1:0] tag;
    logic [ADDR_W-1:0] pbase;
    logic [ADDR_W-1:0] mmask;
    logic [PTE_W-1:0]  pte;
    logic [ADDR_W-1:0] pte_addr;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_fill_prep.sv
module tlb_fill_prep
  import tlb_pkg::*;
#(
  parameter int PGOFF_W   = 12,
  parameter int LVL_IDX_W = 9,
  parameter int LVL_W     = 2
) (
  input  logic [ASID_W-1:0] asid_i,
  input  logic              glob_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [PTE_W-1:0]  pte_i,
  input  logic [ADDR_W-1:0] pte_addr_i,
  output tlb_entry_t        entry_o
);
  localparam int SHIFT_W   = $clog2(ADDR_W + 1);
  localparam int MAX_SHIFT = PGOFF_W + ((1 << LVL_W) - 1) * LVL_IDX_W;

  // The deepest level must still fit in the address.
  if (MAX_SHIFT > ADDR_W) begin : g_shift_too_wide
    $error("page shift exceeds address width");
  end

  logic [SHIFT_W-1:0] shift;
  logic [ADDR_W-1:0]  mmask;

  always_comb begin
    shift = SHIFT_W'(PGOFF_W) + SHIFT_W'(level_i) * SHIFT_W'(LVL_IDX_W);
    mmask = {ADDR_W{1'b1}} << shift;
    entry_o.asid     = asid_i;
    entry_o.glob     = glob_i;
    entry_o.tag      = vaddr_i & mmask;
    entry_o.pbase    = paddr_i & mmask;
    entry_o.mmask    = mmask;
    entry_o.pte      = pte_i;
    entry_o.pte_addr = pte_addr_i;
  end
endmodule

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_pkg::*;
(
  input  logic              valid_i,
  input  tlb_entry_t        entry_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [ADDR_W-1:0] lk_vaddr_i,
  input  logic              fence_valid_i,
  input  logic              fence_use_asid_i,
  input  logic [ASID_W-1:0] fence_asid_i,
  input  logic              fence_use_addr_i,
  input  logic [ADDR_W-1:0] fence_addr_i,
  output logic              lk_match_o,
  output logic              kill_o
);
  logic asid_hit, page_hit, fence_asid_ok, fence_addr_ok;

  always_comb begin
    asid_hit   = entry_i.glob || (entry_i.asid == lk_asid_i);
    page_hit   = entry_i.tag == (lk_vaddr_i & entry_i.mmask);
    lk_match_o = valid_i && asid_hit && page_hit;

    // Identifier-qualified fences never touch global slots.
    fence_asid_ok = !fence_use_asid_i ||
                    ((entry_i.asid == fence_asid_i) && !entry_i.glob);
    fence_addr_ok = !fence_use_addr_i ||
                    (entry_i.tag == (fence_addr_i & entry_i.mmask));
    kill_o = valid_i && fence_valid_i && fence_asid_ok && fence_addr_ok;
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N_SLOTS = 4,
  parameter int AGE_W   = 32,
  localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SLOTS-1:0]            valid_i,
  input  logic [N_SLOTS-1:0][AGE_W-1:0] age_i,
  output logic [IDX_W-1:0]              victim_o
);
  logic found;
  logic [IDX_W-1:0] oldest;

  always_comb begin
    found  = 1'b0;
    oldest = '0;
    for (int i = 1; i < N_SLOTS; i++) begin
      if (age_i[i] < age_i[oldest]) oldest = IDX_W'(i);
    end
    victim_o = oldest;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (!valid_i[i] && !found) begin
        victim_o = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  // R8: a free slot is always preferred over eviction.
  p_victim_prefers_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_i) |-> !valid_i[victim_o]);
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int N_SLOTS      = 4,
  parameter int PGOFF_W      = 12,
  parameter int LVL_IDX_W    = 9,
  parameter int LVL_W        = 2,
  parameter int AGE_W        = 32,
  parameter int FENCE_ASID_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_i,
  input  logic [ASID_W-1:0]       lk_asid_i,
  input  logic [ADDR_W-1:0]       lk_vaddr_i,
  output logic                    lk_hit_o,
  output logic [ADDR_W-1:0]       lk_paddr_o,
  output logic [PTE_W-1:0]        lk_pte_o,
  output logic [ADDR_W-1:0]       lk_pte_addr_o,
  input  logic                    fill_valid_i,
  input  logic [ASID_W-1:0]       fill_asid_i,
  input  logic                    fill_glob_i,
  input  logic [LVL_W-1:0]        fill_level_i,
  input  logic [ADDR_W-1:0]       fill_vaddr_i,
  input  logic [ADDR_W-1:0]       fill_paddr_i,
  input  logic [PTE_W-1:0]        fill_pte_i,
  input  logic [ADDR_W-1:0]       fill_pte_addr_i,
  input  logic                    fence_valid_i,
  input  logic                    fence_use_asid_i,
  input  logic [FENCE_ASID_W-1:0] fence_asid_i,
  input  logic                    fence_use_addr_i,
  input  logic [ADDR_W-1:0]       fence_addr_i
);
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  logic [N_SLOTS-1:0]            valid_q, valid_d, valid_post, kill, lk_match, we;
  tlb_entry_t                    ent_q [N_SLOTS];
  logic [N_SLOTS-1:0][AGE_W-1:0] age_q;
  logic [AGE_W-1:0]              age_cnt_q, age_cnt_d;
  tlb_entry_t                    fill_ent, sel;
  logic [IDX_W-1:0]              victim;
  logic [ASID_W-1:0]             fence_asid;

  assign fence_asid = fence_asid_i[ASID_W-1:0];

  tlb_fill_prep #(.PGOFF_W(PGOFF_W), .LVL_IDX_W(LVL_IDX_W), .LVL_W(LVL_W)) u_prep (
    .asid_i(fill_asid_i), .glob_i(fill_glob_i), .level_i(fill_level_i),
    .vaddr_i(fill_vaddr_i), .paddr_i(fill_paddr_i), .pte_i(fill_pte_i),
    .pte_addr_i(fill_pte_addr_i), .entry_o(fill_ent)
  );

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    tlb_entry_cmp u_cmp (
      .valid_i(valid_q[g]), .entry_i(ent_q[g]),
      .lk_asid_i(lk_asid_i), .lk_vaddr_i(lk_vaddr_i),
      .fence_valid_i(fence_valid_i), .fence_use_asid_i(fence_use_asid_i),
      .fence_asid_i(fence_asid), .fence_use_addr_i(fence_use_addr_i),
      .fence_addr_i(fence_addr_i), .lk_match_o(lk_match[g]), .kill_o(kill[g])
    );

    // R3: stored tag and base carry no bits below the page shift.
    p_tag_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[g] |-> (((ent_q[g].tag | ent_q[g].pbase) & ~ent_q[g].mmask) == '0));

    // R6: a global slot outlives any identifier-qualified fence.
    p_global_survives_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fence_valid_i && fence_use_asid_i && !init_i && valid_q[g] && ent_q[g].glob)
      |=> valid_q[g]);
  end

  tlb_victim_sel #(.N_SLOTS(N_SLOTS), .AGE_W(AGE_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_post), .age_i(age_q), .victim_o(victim)
  );

  // Next state: invalidation first, then the fill lands in the chosen slot.
  always_comb begin
    age_cnt_d  = age_cnt_q + 1'b1;
    valid_post = init_i ? '0 : (valid_q & ~kill);
    valid_d    = valid_post;
    we         = '0;
    if (fill_valid_i) begin
      valid_d[victim] = 1'b1;
      we[victim]      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= '0;
      age_cnt_q <= '0;
    end else begin
      valid_q   <= valid_d;
      age_cnt_q <= age_cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_SLOTS; i++) begin
      if (we[i]) begin
        ent_q[i] <= fill_ent;
        age_q[i] <= age_cnt_q;
      end
    end
  end

  // Lookup: lowest-numbered matching slot wins.
  always_comb begin
    lk_hit_o = 1'b0;
    sel      = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        lk_hit_o = 1'b1;
        sel      = ent_q[i];
      end
    end
    lk_paddr_o    = lk_hit_o ? (sel.pbase | (lk_vaddr_i & ~sel.mmask)) : '0;
    lk_pte_o      = sel.pte;
    lk_pte_addr_o = sel.pte_addr;
  end

  // R4: an unqualified fence with no fill leaves the cache empty.
  p_full_fence_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid_i && !fence_use_asid_i && !fence_use_addr_i && !fill_valid_i)
    |=> (valid_q == '0));

  // R9: a fill always leaves at least one valid slot, whatever else shares the cycle.
  p_fill_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_i |=> (valid_q != '0));

  // R12: a miss drives zero on the translated address.
  p_miss_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit_o |-> (lk_paddr_o == '0) && (lk_pte_o == '0));
endmodule

// File: tb/tlb_cache_tb.sv
module tlb_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        init_i;
  logic [15:0] lk_asid;
  logic [63:0] lk_vaddr;
  logic        lk_hit_o;
  logic [63:0] lk_paddr_o, lk_pte_o, lk_pte_addr_o;
  logic        fill_valid, fill_glob;
  logic [15:0] fill_asid;
  logic [1:0]  fill_level;
  logic [63:0] fill_vaddr, fill_paddr, fill_pte, fill_pte_addr;
  logic        fence_valid, fence_use_asid, fence_use_addr;
  logic [63:0] fence_asid, fence_addr;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_cache u_dut (
    .clk(clk), .rst_n(rst_n), .init_i(init_i),
    .lk_asid_i(lk_asid), .lk_vaddr_i(lk_vaddr), .lk_hit_o(lk_hit_o),
    .lk_paddr_o(lk_paddr_o), .lk_pte_o(lk_pte_o), .lk_pte_addr_o(lk_pte_addr_o),
    .fill_valid_i(fill_valid), .fill_asid_i(fill_asid), .fill_glob_i(fill_glob),
    .fill_level_i(fill_level), .fill_vaddr_i(fill_vaddr), .fill_paddr_i(fill_paddr),
    .fill_pte_i(fill_pte), .fill_pte_addr_i(fill_pte_addr),
    .fence_valid_i(fence_valid), .fence_use_asid_i(fence_use_asid),
    .fence_asid_i(fence_asid), .fence_use_addr_i(fence_use_addr),
    .fence_addr_i(fence_addr)
  );

  // Bench model of the slots.
  bit          m_valid [NE];
  bit          m_glob  [NE];
  logic [15:0] m_asid  [NE];
  logic [63:0] m_tag [NE], m_mask [NE], m_pbase [NE], m_pte [NE], m_ptea [NE];
  int          m_age [NE];
  int          m_now = 0;

  task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_idx();
    for (int i = 0; i < NE; i++)
      if (m_valid[i] && (m_glob[i] || m_asid[i] == lk_asid) &&
          m_tag[i] == (lk_vaddr & m_mask[i])) return i;
    return -1;
  endfunction

  task automatic model_update();
    bit kill [NE];
    int v;
    for (int i = 0; i < NE; i++) begin
      bit a_ok, d_ok;
      a_ok = !fence_use_asid || (m_asid[i] == fence_asid[15:0] && !m_glob[i]);
      d_ok = !fence_use_addr || (m_tag[i] == (fence_addr & m_mask[i]));
      kill[i] = fence_valid && a_ok && d_ok;
    end
    for (int i = 0; i < NE; i++) if (kill[i] || init_i) m_valid[i] = 0;
    if (fill_valid) begin
      v = -1;
      for (int i = 0; i < NE; i++) if (!m_valid[i] && v < 0) v = i;
      if (v < 0) begin
        v = 0;
        for (int i = 1; i < NE; i++) if (m_age[i] < m_age[v]) v = i;
      end
      m_valid[v] = 1;
      m_glob[v]  = fill_glob;
      m_asid[v]  = fill_asid;
      m_mask[v]  = 64'hFFFF_FFFF_FFFF_FFFF << (12 + 9 * fill_level);
      m_tag[v]   = fill_vaddr & m_mask[v];
      m_pbase[v] = fill_paddr & m_mask[v];
      m_pte[v]   = fill_pte;
      m_ptea[v]  = fill_pte_addr;
      m_age[v]   = m_now;
    end
    m_now++;
  endtask

  // One cycle: check the combinational lookup, then advance model and DUT.
  task automatic tick(string req);
    int e;
    #1;
    e = exp_idx();
    check_eq(req, {63'd0, lk_hit_o}, {63'd0, e >= 0});
    if (e >= 0) begin
      check_eq(req, lk_paddr_o, m_pbase[e] | (lk_vaddr & ~m_mask[e]));
      check_eq({req, " R12 pte"}, lk_pte_o, m_pte[e]);
      check_eq({req, " R12 pte_addr"}, lk_pte_addr_o, m_ptea[e]);
    end else begin
      check_eq({req, " R12 miss"}, lk_paddr_o, 64'd0);
    end
    model_update();
    @(negedge clk);
    fill_valid = 0; fence_valid = 0; init_i = 0;
  endtask

  task automatic look(logic [15:0] a, logic [63:0] va, string req);
    lk_asid = a; lk_vaddr = va;
    tick(req);
  endtask

  task automatic fill(logic [15:0] a, bit g, logic [1:0] lvl, logic [63:0] va, logic [63:0] pa);
    fill_valid = 1; fill_asid = a; fill_glob = g; fill_level = lvl;
    fill_vaddr = va; fill_paddr = pa; fill_pte = pa ^ 64'h5A5A;
    fill_pte_addr = va ^ 64'hFF00_0000_0000_0FF8;
  endtask

  task automatic fence(bit ua, logic [63:0] a, bit ud, logic [63:0] d);
    fence_valid = 1; fence_use_asid = ua; fence_asid = a;
    fence_use_addr = ud; fence_addr = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int r;
    rst_n = 0; init_i = 0; lk_asid = 0; lk_vaddr = 0;
    fill_valid = 0; fill_asid = 0; fill_glob = 0; fill_level = 0;
    fill_vaddr = 0; fill_paddr = 0; fill_pte = 0; fill_pte_addr = 0;
    fence_valid = 0; fence_use_asid = 0; fence_asid = 0; fence_use_addr = 0; fence_addr = 0;
    for (int i = 0; i < NE; i++) m_valid[i] = 0;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check_eq("R10 in reset", {63'd0, lk_hit_o}, 64'd0);
    rst_n = 1;
    look(16'd5, 64'h0000_0040_1234_5678, "R10 after reset");

    // R2 / R3 level 0 with junk low physical bits
    fill(16'd5, 0, 2'd0, 64'h0000_0040_1234_5000, 64'h0000_0000_8000_1FFF);
    look(16'd5, 64'h0000_0040_1234_5ABC, "R3 level0 offset");
    look(16'd5, 64'h0000_0040_1234_6000, "R2 level0 next page");
    look(16'd6, 64'h0000_0040_1234_5ABC, "R1 other asid");
    // R2 level 1
    fill(16'd5, 0, 2'd1, 64'h0000_0000_4020_0000, 64'h0000_0001_00BF_F123);
    look(16'd5, 64'h0000_0000_403F_F654, "R2 level1 in page");
    look(16'd5, 64'h0000_0000_4040_0000, "R2 level1 past page");
    // R2 level 2 global
    fill(16'd9, 1, 2'd2, 64'h0000_0080_4000_0000, 64'h0000_0002_3FFF_FFFF);
    look(16'd3, 64'h0000_0080_7FFF_FFF0, "R1 global other asid");
    look(16'd3, 64'h0000_0080_8000_0000, "R2 level2 past page");
    // R6 identifier fence, upper operand bits junk; global survives
    fence(1, 64'hABCD_0000_0000_0005, 0, 64'd0);
    look(16'd5, 64'h0000_0040_1234_5ABC, "R6 before fence");
    look(16'd5, 64'h0000_0040_1234_5ABC, "R6 asid fenced");
    look(16'd5, 64'h0000_0000_403F_F654, "R6 asid fenced lvl1");
    look(16'd7, 64'h0000_0080_4000_1000, "R6 global survives");
    // R5 address-only fence kills global
    fence(0, 64'd0, 1, 64'h0000_0080_5555_0000);
    look(16'd7, 64'h0000_0080_4000_1000, "R5 before fence");
    look(16'd7, 64'h0000_0080_4000_1000, "R5 global fenced by addr");
    // R7 both fields
    fill(16'd7, 0, 2'd0, 64'h0000_0000_0001_0000, 64'h0000_0000_1111_0000); tick("R7 fill a");
    fill(16'd8, 0, 2'd0, 64'h0000_0000_0001_0000, 64'h0000_0000_2222_0000); tick("R7 fill b");
    fill(16'd8, 1, 2'd0, 64'h0000_0000_0002_0000, 64'h0000_0000_3333_0000); tick("R7 fill g");
    fence(1, 64'd7, 1, 64'h0000_0000_0001_0ABC); tick("R7 fence");
    look(16'd7, 64'h0000_0000_0001_0010, "R7 asid7 gone");
    look(16'd8, 64'h0000_0000_0001_0010, "R7 asid8 kept");
    fence(1, 64'd8, 1, 64'h0000_0000_0002_0000); tick("R7 fence global");
    look(16'd8, 64'h0000_0000_0002_0040, "R7 global kept");
    // R4 full fence
    fence(0, 64'd0, 0, 64'd0); tick("R4 fence all");
    look(16'd8, 64'h0000_0000_0002_0040, "R4 global gone");
    look(16'd8, 64'h0000_0000_0001_0010, "R4 other gone");
    // R8 replacement order
    for (int k = 0; k < 5; k++) begin
      fill(16'd1, 0, 2'd0, 64'h0000_0000_1000_0000 + 64'(k) * 64'h1000, 64'h0000_0000_9000_0000 + 64'(k) * 64'h1000);
      tick("R8 fill");
    end
    for (int k = 0; k < 5; k++) look(16'd1, 64'h0000_0000_1000_0008 + 64'(k) * 64'h1000, "R8 oldest evicted");
    fence(0, 64'd0, 1, 64'h0000_0000_1000_2000); tick("R8 free middle");
    fill(16'd1, 0, 2'd0, 64'h0000_0000_1000_7000, 64'h0000_0000_9000_7000); tick("R8 refill");
    for (int k = 1; k < 8; k++) look(16'd1, 64'h0000_0000_1000_0008 + 64'(k) * 64'h1000, "R8 freed slot reused");
    // R9 fence and init with fill in same cycle
    fence(0, 64'd0, 0, 64'd0);
    fill(16'd2, 0, 2'd0, 64'h0000_0000_2000_0000, 64'h0000_0000_A000_0000); tick("R9 fence+fill");
    look(16'd2, 64'h0000_0000_2000_0004, "R9 fill survives fence");
    look(16'd1, 64'h0000_0000_1000_4008, "R9 old gone");
    init_i = 1;
    fill(16'd2, 0, 2'd0, 64'h0000_0000_3000_0000, 64'h0000_0000_B000_0000); tick("R9 init+fill");
    look(16'd2, 64'h0000_0000_3000_0004, "R9 fill survives init");
    look(16'd2, 64'h0000_0000_2000_0004, "R9 init cleared");
    // R11 duplicates
    fill(16'd4, 0, 2'd0, 64'h0000_0000_4000_0000, 64'h0000_0000_C000_0000); tick("R11 dup a");
    fill(16'd4, 0, 2'd0, 64'h0000_0000_4000_0000, 64'h0000_0000_D000_0000); tick("R11 dup b");
    look(16'd4, 64'h0000_0000_4000_0123, "R11 lowest wins");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] pg;
      pg = 64'h0000_0000_5000_0000 + 64'($urandom_range(0, 7)) * 64'h1000
           + 64'($urandom_range(0, 1)) * 64'h20_0000;
      lk_asid  = 16'($urandom_range(1, 3));
      lk_vaddr = pg | 64'($urandom_range(0, 4095));
      if ($urandom_range(0, 2) == 0)
        fill(16'($urandom_range(1, 3)), $urandom_range(0, 7) == 0, 2'($urandom_range(0, 2)),
             64'h0000_0000_5000_0000 + 64'($urandom_range(0, 7)) * 64'h1000,
             {32'h0, $urandom()});
      if ($urandom_range(0, 9) == 0)
        fence($urandom_range(0, 1) == 1, {$urandom(), 16'h0, 16'($urandom_range(1, 3))},
              $urandom_range(0, 1) == 1, pg);
      if ($urandom_range(0, 99) == 0) init_i = 1;
      tick("R1 R11 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule